// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the management-side slave of a serial two-wire station interface. It uses MDC as its clock, samples the MDIO input on each rising MDC edge and decodes frames. A frame is a run of ones, a start delimiter, a two-bit operation, a five-bit device address, a five-bit register address, a two-bit turnaround and a sixteen-bit data word. Frames addressed to this device read or write a bank of thirty-two 16-bit registers. On a read, the block turns the line around and shifts the selected register out on MDIO.

Two registers have fixed roles. Register 1 is a constant identification word, except that bit 6 enables frames with no leading run of ones. Register 16 holds the device address in bits 4..0, latched from strap pins at reset. Its bit 15 is a guard: register 1 bit 6 can be changed only while that guard is set. A side observation port shows the value of any register at any time.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset mdio_oe is 0, register 1 reads REG1_INIT (default 16'h7809, bit 6 clear) and register 16 bits 4..0 equal phy_strap.
- R2: While register 1 bit 6 is 0, a frame is accepted only if at least 32 consecutive ones precede its delimiter; with 31 ones, or none, the frame is ignored.
- R3: The start delimiter is 0 followed by 1 on consecutive edges; a frame whose delimiter is 0,0 is ignored.
- R4: Operation 2'b10 reads and 2'b01 writes, sent MSB first; operations 2'b00 and 2'b11 drive nothing and change no register.
- R5: A frame whose five address bits (MSB first) differ from register 16 bits 4..0 drives nothing and changes no register.
- R6: Let edge E be the rising edge that samples the last register-address bit of a matching read. mdio_oe stays 0 after E. After E+1, mdio_oe is 1 and mdio_out is 0. After edge E+2+i, mdio_out carries data bit 15-i. After E+18, mdio_oe is 0 again.
- R7: A write needs turnaround 1 then 0, followed by 16 data bits MSB first. The register holds the new word from the edge that samples the last data bit. Any other turnaround aborts the write.
- R8: Register 1 ignores writes except bit 6, and bit 6 takes the written value only while register 16 bit 15 is 1.
- R9: While register 1 bit 6 is 1, a frame may begin directly with its delimiter, with no ones before it.
- R10: Register 16 bits 4..0 ignore writes; all other bits of register 16 and all other registers store what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_in | input | 1 | Sampled management data line |
| phy_strap | input | 5 | Device address straps, latched during reset |
| mdio_out | output | 1 | Driven management data |
| mdio_oe | output | 1 | High while the block drives the line |
| obs_addr | input | 5 | Register index for the observation port |
| obs_data | output | 16 | Current value of register obs_addr |

## Verification
All timing is counted from edge E, the edge that samples the last register-address bit. On a read, mdio_oe and mdio_out are registered. The turnaround zero is therefore due after E+1, data bit 15-i after E+2+i, and the release after E+18. The bench drives each bit on a falling edge and reads the outputs at that same falling edge, half a cycle after the edge that produced them. A write commits on the edge that samples its last data bit, so the observation port is read at the next falling edge. For ignored frames, mdio_oe is watched at every falling edge of the frame, and the target register is read back through the observation port afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SFD, ST_HDR, ST_TA1, ST_TA2, ST_DATA
  } fsm_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam int SUP_REG = 1;
  localparam int SUP_BIT = 6;
  localparam int OVR_REG = 16;
  localparam int OVR_BIT = 15;
endpackage

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] REG1_INIT = 16'h7809
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] phy_strap,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data,
  output logic              sup_en,
  output logic [ADDR_W-1:0] phy_addr
);
  localparam int NREG = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] R1_FIXED = REG1_INIT & ~(DATA_W'(1) << SUP_BIT);

  logic [DATA_W-1:0] store [NREG];
  logic [DATA_W-1:0] view  [NREG];
  logic              sup_q;
  logic [ADDR_W-1:0] phy_q;
  logic              ovr;

  assign ovr = store[OVR_REG][OVR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
      sup_q <= 1'b0;
      phy_q <= phy_strap;
    end else if (we) begin
      if (waddr == ADDR_W'(SUP_REG)) begin
        if (ovr) sup_q <= wdata[SUP_BIT];
      end else begin
        store[waddr] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    if (g == SUP_REG) begin : g_sup
      assign view[g] = R1_FIXED | (DATA_W'(sup_q) << SUP_BIT);
    end else if (g == OVR_REG) begin : g_ovr
      assign view[g] = {store[g][DATA_W-1:ADDR_W], phy_q};
    end else begin : g_plain
      assign view[g] = store[g];
    end
  end

  assign rdata    = view[raddr];
  assign obs_data = view[obs_addr];
  assign sup_en   = sup_q;
  assign phy_addr = phy_q;

  // R8: suppression enable may only turn on while the guard bit was set
  a_r8_guarded_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_q) |-> $past(ovr));

  // R10: latched device address never moves outside reset
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(phy_q));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              sup_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int HDR_W = 2 + 2 * ADDR_W;
  localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  fsm_st_e           st;
  logic [PRE_W-1:0]  pre;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [HDR_W-1:0]  hdr_nxt;
  logic [DATA_W-1:0] dsh;
  logic              rd;
  logic [1:0]        op_nxt;
  logic [ADDR_W-1:0] phy_nxt;

  assign hdr_nxt = {hdr[HDR_W-2:0], mdio_in};
  assign op_nxt  = hdr_nxt[HDR_W-1 -: 2];
  assign phy_nxt = hdr_nxt[2*ADDR_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; pre <= '0; cnt <= '0; hdr <= '0;
      dsh <= '0; rd <= 1'b0; mdio_oe <= 1'b0; mdio_out <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (mdio_in) begin
            if (pre != PRE_W'(PRE_LEN)) pre <= pre + 1'b1;
          end else begin
            if (pre == PRE_W'(PRE_LEN) || sup_en) st <= ST_SFD;
            pre <= '0;
          end
        end
        ST_SFD: begin
          cnt <= '0;
          st  <= mdio_in ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr <= hdr_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(HDR_W - 1)) begin
            cnt <= '0;
            if ((op_nxt == OP_RD || op_nxt == OP_WR) && phy_nxt == phy_addr) begin
              st <= ST_TA1;
              rd <= (op_nxt == OP_RD);
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_TA1: begin
          cnt <= '0;
          if (rd) begin
            mdio_oe  <= 1'b1;
            mdio_out <= 1'b0;
            dsh      <= rdata;
            st       <= ST_DATA;
          end else begin
            st <= mdio_in ? ST_TA2 : ST_IDLE;
          end
        end
        ST_TA2: begin
          cnt <= '0;
          st  <= mdio_in ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (rd) begin
            if (cnt == CNT_W'(DATA_W)) begin
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              mdio_out <= dsh[DATA_W-1];
              dsh      <= {dsh[DATA_W-2:0], 1'b0};
              cnt      <= cnt + 1'b1;
            end
          end else begin
            dsh <= {dsh[DATA_W-2:0], mdio_in};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign raddr = hdr[ADDR_W-1:0];
  assign waddr = hdr[ADDR_W-1:0];
  assign we    = (st == ST_DATA) && !rd && (cnt == CNT_W'(DATA_W - 1));
  assign wdata = {dsh[DATA_W-2:0], mdio_in};

  // Length of each drive burst, for the R6 window check
  logic [CNT_W:0] oe_run;
  always_ff @(posedge clk) begin
    if (rst)          oe_run <= '0;
    else if (mdio_oe) oe_run <= oe_run + 1'b1;
    else              oe_run <= '0;
  end

  // R6: the first driven bit is the turnaround zero
  a_r6_ta_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_out);

  // R6: a drive burst lasts the turnaround bit plus one data word
  a_r6_burst_len: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> oe_run == (CNT_W+1)'(DATA_W + 1));

  // R7: a write never commits while the line is being driven
  a_r7_no_write_on_read: assert property (@(posedge clk) disable iff (rst)
    we |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter logic [DATA_W-1:0] REG1_INIT = 16'h7809
) (
  input  logic              mdc,
  input  logic              rst,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] phy_strap,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data
);
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              sup_en;
  logic [ADDR_W-1:0] phy_addr;

  mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) fsm_i (
    .clk(mdc), .rst(rst), .mdio_in(mdio_in), .phy_addr(phy_addr),
    .sup_en(sup_en), .rdata(rdata), .raddr(raddr), .we(we),
    .waddr(waddr), .wdata(wdata), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  mdio_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG1_INIT(REG1_INIT)) bank_i (
    .clk(mdc), .rst(rst), .phy_strap(phy_strap), .we(we), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata), .obs_addr(obs_addr),
    .obs_data(obs_data), .sup_en(sup_en), .phy_addr(phy_addr)
  );
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;
  localparam logic [4:0]  STRAP  = 5'h0B;
  localparam logic [4:0]  OTHER  = 5'h0A;
  localparam logic [15:0] R1INIT = 16'h7809;

  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_in = 1'b1;
  logic [4:0]  phy_strap = STRAP;
  logic        mdio_out;
  logic        mdio_oe;
  logic [4:0]  obs_addr = '0;
  logic [15:0] obs_data;

  int vec = 0;
  int err = 0;
  bit done = 1'b0;

  always #5 mdc = ~mdc;

  mdio_mgmt_slave dut_i (
    .mdc(mdc), .rst(rst), .mdio_in(mdio_in), .phy_strap(phy_strap),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .obs_addr(obs_addr), .obs_data(obs_data)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  function automatic logic [15:0] pat(input int r);
    return (16'(r * 16'h0A53) ^ 16'h3C5A) & 16'h7FFF;
  endfunction

  task automatic peek(input logic [4:0] a, output logic [15:0] v);
    obs_addr = a;
    #1;
    v = obs_data;
  endtask

  // One frame. For a matching read (resp=1, op=10) the drive timing is
  // checked against edge E; otherwise mdio_oe must stay low and the
  // target register must read exp afterwards.
  task automatic frame(input int pre, input logic [1:0] sfd, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input logic [1:0] ta, input logic [15:0] wd,
                       input bit resp, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    logic        seen_oe;
    logic        ok;
    put(1'b0); put(1'b0);
    repeat (pre) put(1'b1);
    put(sfd[1]); put(sfd[0]);
    put(op[1]); put(op[0]);
    for (int i = 4; i >= 0; i--) put(phy[i]);
    for (int i = 4; i >= 0; i--) put(ra[i]);          // last bit sampled at edge E
    if (resp && op == 2'b10) begin
      put(1'b1);                                       // after E
      ok = !mdio_oe;
      put(1'b1);                                       // after E+1
      ok = ok && mdio_oe && !mdio_out;
      chk({tag, " R6 turnaround"}, {15'd0, ok}, 16'd1);
      got = '0;
      ok  = 1'b1;
      for (int i = 0; i < 16; i++) begin
        put(1'b1);                                     // after E+2+i
        got = {got[14:0], mdio_out};
        ok  = ok && mdio_oe;
      end
      chk({tag, " R6 read data"}, ok ? got : 16'hxxxx, exp);
      put(1'b1);                                       // after E+18
      chk({tag, " R6 release"}, {15'd0, mdio_oe}, 16'd0);
      put(1'b1);
    end else begin
      seen_oe = 1'b0;
      put(ta[1]); seen_oe = seen_oe | mdio_oe;
      put(ta[0]); seen_oe = seen_oe | mdio_oe;
      for (int i = 15; i >= 0; i--) begin
        put(wd[i]); seen_oe = seen_oe | mdio_oe;
      end
      put(1'b1);                                       // after the commit edge
      seen_oe = seen_oe | mdio_oe;
      peek(ra, got);
      chk({tag, " R7 register value"}, got, exp);
      put(1'b1); seen_oe = seen_oe | mdio_oe;
      if (!resp) chk({tag, " R4 R5 no drive"}, {15'd0, seen_oe}, 16'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    err++; vec++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] expv;
    repeat (4) @(posedge mdc);
    @(negedge mdc) rst = 1'b0;
    repeat (2) @(negedge mdc);

    // R1 reset state
    chk("R1 oe after reset", {15'd0, mdio_oe}, 16'd0);
    peek(5'd1, v);  chk("R1 reg1 reset", v, R1INIT);
    peek(5'd16, v); chk("R1 reg16 strap", v, {11'd0, STRAP});

    // R7 R10: write every register with a computed pattern (bit 15 clear)
    for (int r = 0; r < 32; r++) begin
      expv = (r == 1) ? R1INIT : (r == 16) ? {pat(r)[15:5], STRAP} : pat(r);
      frame(32, 2'b01, 2'b01, STRAP, 5'(r), 2'b10, pat(r), 1'b1, expv, "sweep write");
    end
    // R6 R8 R10: read every register back over the serial line
    for (int r = 0; r < 32; r++) begin
      expv = (r == 1) ? R1INIT : (r == 16) ? {pat(r)[15:5], STRAP} : pat(r);
      frame(32, 2'b01, 2'b10, STRAP, 5'(r), 2'b11, 16'hFFFF, 1'b1, expv, "sweep read");
    end

    // R4: undefined operations
    frame(32, 2'b01, 2'b00, STRAP, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R4 op00");
    frame(32, 2'b01, 2'b11, STRAP, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R4 op11");
    // R5: other device address, write and read
    frame(32, 2'b01, 2'b01, OTHER, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R5 wr mismatch");
    frame(32, 2'b01, 2'b10, OTHER, 5'd5, 2'b11, 16'hFFFF, 1'b0, pat(5), "R5 rd mismatch");
    // R2: one short of a full preamble, and none at all
    frame(31, 2'b01, 2'b01, STRAP, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R2 31 ones");
    frame(0,  2'b01, 2'b01, STRAP, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R2 no preamble");
    // R3: bad delimiter
    frame(32, 2'b00, 2'b01, STRAP, 5'd5, 2'b10, 16'hBEEF, 1'b0, pat(5), "R3 sfd 00");
    // R7: bad turnaround on a write
    frame(32, 2'b01, 2'b01, STRAP, 5'd5, 2'b11, 16'hBEEF, 1'b0, pat(5), "R7 bad ta");

    // R8: reg1 write without guard has no effect
    frame(32, 2'b01, 2'b01, STRAP, 5'd1, 2'b10, 16'hFFFF, 1'b1, R1INIT, "R8 unguarded");
    frame(32, 2'b01, 2'b10, STRAP, 5'd1, 2'b11, 16'hFFFF, 1'b1, R1INIT, "R8 read reg1");
    // R10: set the guard; low bits stay at the strap value
    frame(32, 2'b01, 2'b01, STRAP, 5'd16, 2'b10, 16'h801F, 1'b1, {11'h400, STRAP}, "R10 guard");
    // R8: guarded write sets bit 6 only
    frame(32, 2'b01, 2'b01, STRAP, 5'd1, 2'b10, 16'hFFFF, 1'b1, R1INIT | 16'h0040, "R8 guarded");
    // R9: frames with no preamble now accepted
    frame(0, 2'b01, 2'b01, STRAP, 5'd7, 2'b10, 16'h1234, 1'b1, 16'h1234, "R9 write");
    frame(0, 2'b01, 2'b10, STRAP, 5'd7, 2'b11, 16'hFFFF, 1'b1, 16'h1234, "R9 read");
    // R8: clear suppression again, then R2: no preamble is ignored
    frame(0, 2'b01, 2'b01, STRAP, 5'd1, 2'b10, 16'h0000, 1'b1, R1INIT, "R8 clear");
    frame(0, 2'b01, 2'b01, STRAP, 5'd7, 2'b10, 16'h4321, 1'b0, 16'h1234, "R2 off again");

    summary();
  end
endmodule